// File: doc/BRIEF.md
# Interrupt acceptance and vectoring unit

This unit sits next to a small processor core and decides, once per instruction boundary, whether the core must leave its current instruction stream. Three request sources feed it. A reset request and a non-maskable request each arrive as single-cycle pulses and are held in pending flags. A maskable request arrives as a 3-bit priority level from an external interrupt controller, and the controller keeps that level steady until it changes it. The unit compares the pending maskable level against the interrupt-enable bit and the level mask in the core's status word.

When the unit accepts an interrupt, it drives the core's redirect target, the replacement status word and the new stack pointer. It also drives two stack stores that form a frame: the program counter as a 32-bit word and the old status word as a 16-bit half. For a maskable entry it raises an acknowledge that carries the accepted level. The branch target of a maskable entry is a fixed base plus a per-level 16-bit offset. Software sets these offsets through a small register window on a 16-bit memory-mapped bus. The window also exposes two constant read-only words.

The core sends the register window offset relative to a block base that is 4-byte aligned. The unit decodes only the low 7 offset bits.

Top module: `irq_accept_unit`

## Requirements
- R1: The unit acts only in a cycle where `boundary` is 1, and it takes at most one action in that cycle. The priority order is reset request, then non-maskable request, then maskable level.
- R2: A pulse on `rst_req_in` sets a pending reset. At the next boundary, `reset_req` is 1 for that cycle, `entry_vld` stays 0 and the pending reset is cleared.
- R3: A pulse on `nmi_in` sets a pending non-maskable request, and this request ignores the status word. Its acceptance clears the pending flag, so the following boundary does not repeat it.
- R4: Any entry drives the following. `st_word_addr` is `cur_sp`-4 and `st_word_data` is `cur_pc`. `st_half_addr` is `cur_sp`-8 and `st_half_data` is `cur_sr`. `new_sp` is `cur_sp`-8. `new_sr` is `cur_sr` with the enable bit (bit 11) cleared. A non-maskable entry leaves all other status bits unchanged and redirects to 0x40000008.
- R5: The pending level is `lvl_in` registered once. Level L is accepted only when status bit 11 is 1 and L is below the mask held in status bits 10:8. Level 7 means that no request is pending.
- R6: A maskable entry of level L writes L into `new_sr` bits 10:8 and redirects to 0x40000000 plus the zero-extended vector register L.
- R7: A maskable entry sets `ack_vld` with `ack_lvl` = L. Acceptance does not clear the pending level, so the same level is offered again at later boundaries.
- R8: After `rst`, no reset or non-maskable request is pending, the pending level is 7 and every vector register reads 0.
- R9: Vector register i (0 to 6) holds 16 bits at byte offset 4*i, and a read returns it on `bus_rdata` in the same cycle.
- R10: Offset 0x20 reads the constant `MEMCTL_VAL` and offset 0x40 reads `MODE_VAL`. Every other undecoded offset reads 0.
- R11: A write changes state only when `bus_two` is 1 (a 2-byte access) and the offset is a vector offset. A write to any other offset, or a write of any other size, leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_in | input | 1 | Reset request pulse |
| nmi_in | input | 1 | Non-maskable request pulse |
| lvl_in | input | 3 | Encoded maskable level, 7 = none |
| boundary | input | 1 | Instruction boundary strobe |
| cur_pc | input | 32 | Core program counter |
| cur_sr | input | 16 | Core status word (bit 11 enable, bits 10:8 mask) |
| cur_sp | input | 32 | Core stack pointer |
| bus_sel | input | 1 | Register window access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_two | input | 1 | Access is 2 bytes wide |
| bus_addr | input | 7 | Byte offset in window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| reset_req | output | 1 | Reset action taken this boundary |
| entry_vld | output | 1 | Interrupt entry taken this boundary |
| redir_pc | output | 32 | Redirect target |
| new_sr | output | 16 | Replacement status word |
| new_sp | output | 32 | Replacement stack pointer |
| st_word_addr | output | 32 | Address of PC store |
| st_word_data | output | 32 | PC store data |
| st_half_addr | output | 32 | Address of status store |
| st_half_data | output | 16 | Status store data |
| ack_vld | output | 1 | Maskable acknowledge |
| ack_lvl | output | 3 | Acknowledged level |

## Verification
The assertions take these input conditions for granted. `rst_req_in` and `nmi_in` are single-cycle pulses. `lvl_in` changes only on clock edges. `cur_sr`, `cur_pc` and `cur_sp` are stable during a boundary cycle. The stimulus follows these conditions: it changes every input just after the falling edge and keeps each pulse to one cycle. It also applies each boundary strobe only once the registered level has settled. The stimulus sweeps every combination of pending level, mask and enable bit, so the acceptance rule is covered completely.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W      = 3;
    localparam int NUM_VEC    = 7;
    localparam int OFF_W      = 7;
    localparam int SR_W       = 16;
    localparam int ADR_W      = 32;
    localparam int SR_IE_BIT  = 11;
    localparam int SR_LM_LO   = 8;
    localparam logic [LVL_W-1:0] IDLE_LVL = 3'd7;
    localparam logic [ADR_W-1:0] NMI_TARGET = 32'h4000_0008;
    localparam logic [ADR_W-1:0] VEC_BASE   = 32'h4000_0000;
    localparam logic [OFF_W-1:0] MEMCTL_OFF = 7'h20;
    localparam logic [OFF_W-1:0] MODE_OFF   = 7'h40;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_NMI,
        ACT_LEVEL
    } act_e;

    function automatic logic [LVL_W-1:0] sr_mask(input logic [SR_W-1:0] sr);
        return sr[SR_LM_LO +: LVL_W];
    endfunction

    function automatic logic sr_ie(input logic [SR_W-1:0] sr);
        return sr[SR_IE_BIT];
    endfunction
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
    import irq_pkg::*;
#(
    parameter logic [15:0] MEMCTL_VAL = 16'h0000,
    parameter logic [15:0] MODE_VAL   = 16'h0000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic                         bus_two,
    input  logic [OFF_W-1:0]             bus_addr,
    input  logic [15:0]                  bus_wdata,
    output logic [15:0]                  bus_rdata,
    output logic [NUM_VEC-1:0][15:0]     vec_q
);
    logic wr_ok;
    assign wr_ok = bus_sel && bus_wr && bus_two;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (wr_ok && bus_addr == OFF_W'(4 * i))
                    vec_q[i] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == MEMCTL_OFF) bus_rdata = MEMCTL_VAL;
            if (bus_addr == MODE_OFF)   bus_rdata = MODE_VAL;
            for (int i = 0; i < NUM_VEC; i++) begin
                if (bus_addr == OFF_W'(4 * i))
                    bus_rdata = vec_q[i];
            end
        end
    end

    // R11
    size_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !bus_two) |=> $stable(vec_q));
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req_in,
    input  logic             nmi_in,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic             clr_rst,
    input  logic             clr_nmi,
    output logic             rst_pend,
    output logic             nmi_pend,
    output logic [LVL_W-1:0] lvl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
            lvl_q    <= IDLE_LVL;
        end else begin
            lvl_q <= lvl_in;
            if (rst_req_in)   rst_pend <= 1'b1;
            else if (clr_rst) rst_pend <= 1'b0;
            if (nmi_in)       nmi_pend <= 1'b1;
            else if (clr_nmi) nmi_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_pkg::*;
(
    input  logic                     boundary,
    input  logic                     rst_pend,
    input  logic                     nmi_pend,
    input  logic [LVL_W-1:0]         lvl_q,
    input  logic [NUM_VEC-1:0][15:0] vec_q,
    input  logic [ADR_W-1:0]         cur_pc,
    input  logic [SR_W-1:0]          cur_sr,
    input  logic [ADR_W-1:0]         cur_sp,
    output act_e                     act,
    output logic [ADR_W-1:0]         redir_pc,
    output logic [SR_W-1:0]          new_sr,
    output logic [ADR_W-1:0]         new_sp,
    output logic [ADR_W-1:0]         st_word_addr,
    output logic [ADR_W-1:0]         st_word_data,
    output logic [ADR_W-1:0]         st_half_addr,
    output logic [SR_W-1:0]          st_half_data
);
    logic        lvl_ok;
    logic [15:0] vec_sel;

    assign lvl_ok = (lvl_q != IDLE_LVL) && (lvl_q < sr_mask(cur_sr)) && sr_ie(cur_sr);

    always_comb begin
        vec_sel = '0;
        for (int i = 0; i < NUM_VEC; i++)
            if (lvl_q == LVL_W'(i)) vec_sel = vec_q[i];
    end

    always_comb begin
        if (!boundary)     act = ACT_NONE;
        else if (rst_pend) act = ACT_RESET;
        else if (nmi_pend) act = ACT_NMI;
        else if (lvl_ok)   act = ACT_LEVEL;
        else               act = ACT_NONE;
    end

    always_comb begin
        st_word_addr = cur_sp - 32'd4;
        st_word_data = cur_pc;
        st_half_addr = cur_sp - 32'd8;
        st_half_data = cur_sr;
        new_sp       = cur_sp - 32'd8;
        new_sr       = cur_sr;
        new_sr[SR_IE_BIT] = 1'b0;
        redir_pc     = NMI_TARGET;
        if (act == ACT_LEVEL) begin
            new_sr[SR_LM_LO +: LVL_W] = lvl_q;
            redir_pc = VEC_BASE + {16'h0000, vec_sel};
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter logic [15:0] MEMCTL_VAL = 16'h00C3,
    parameter logic [15:0] MODE_VAL   = 16'h0051
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rst_req_in,
    input  logic        nmi_in,
    input  logic [2:0]  lvl_in,
    input  logic        boundary,
    input  logic [31:0] cur_pc,
    input  logic [15:0] cur_sr,
    input  logic [31:0] cur_sp,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_two,
    input  logic [6:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        reset_req,
    output logic        entry_vld,
    output logic [31:0] redir_pc,
    output logic [15:0] new_sr,
    output logic [31:0] new_sp,
    output logic [31:0] st_word_addr,
    output logic [31:0] st_word_data,
    output logic [31:0] st_half_addr,
    output logic [15:0] st_half_data,
    output logic        ack_vld,
    output logic [2:0]  ack_lvl
);
    logic [NUM_VEC-1:0][15:0] vec_q;
    logic                     rst_pend, nmi_pend;
    logic [LVL_W-1:0]         lvl_q;
    act_e                     act;

    irq_vec_regs #(.MEMCTL_VAL(MEMCTL_VAL), .MODE_VAL(MODE_VAL)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_two(bus_two), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .vec_q(vec_q)
    );

    irq_pend_track u_pend (
        .clk(clk), .rst(rst), .rst_req_in(rst_req_in), .nmi_in(nmi_in),
        .lvl_in(lvl_in), .clr_rst(act == ACT_RESET), .clr_nmi(act == ACT_NMI),
        .rst_pend(rst_pend), .nmi_pend(nmi_pend), .lvl_q(lvl_q)
    );

    irq_entry_ctl u_ctl (
        .boundary(boundary), .rst_pend(rst_pend), .nmi_pend(nmi_pend),
        .lvl_q(lvl_q), .vec_q(vec_q), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .cur_sp(cur_sp), .act(act), .redir_pc(redir_pc), .new_sr(new_sr),
        .new_sp(new_sp), .st_word_addr(st_word_addr), .st_word_data(st_word_data),
        .st_half_addr(st_half_addr), .st_half_data(st_half_data)
    );

    assign reset_req = (act == ACT_RESET);
    assign entry_vld = (act == ACT_NMI) || (act == ACT_LEVEL);
    assign ack_vld   = (act == ACT_LEVEL);
    assign ack_lvl   = lvl_q;

    // R1
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_req, entry_vld}));
    // R1
    idle_no_action_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary |-> (!reset_req && !entry_vld && !ack_vld));
    // R2
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (reset_req && !rst_req_in) |=> (boundary |-> !reset_req));
    // R3
    nmi_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_vld && !ack_vld && !nmi_in && !rst_req_in) |=> (boundary |-> !(entry_vld && !ack_vld) || !$stable(lvl_q) || ack_vld));
    // R4
    frame_shape_chk: assert property (@(posedge clk) disable iff (rst)
        entry_vld |-> (new_sp == st_half_addr && st_word_addr == st_half_addr + 32'd4 && !new_sr[SR_IE_BIT]));
    // R5
    ack_allowed_chk: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> (cur_sr[SR_IE_BIT] && ack_lvl < cur_sr[SR_LM_LO +: LVL_W]));
    // R7
    level_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && lvl_in == ack_lvl) |=> (lvl_q == $past(ack_lvl)));
endmodule

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        rst_req_in, nmi_in, boundary;
    logic [2:0]  lvl_in;
    logic [31:0] cur_pc, cur_sp;
    logic [15:0] cur_sr;
    logic        bus_sel, bus_wr, bus_two;
    logic [6:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        reset_req, entry_vld, ack_vld;
    logic [31:0] redir_pc, new_sp, st_word_addr, st_word_data, st_half_addr;
    logic [15:0] new_sr, st_half_data;
    logic [2:0]  ack_lvl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_accept_unit dut (
        .clk(clk), .rst(rst), .rst_req_in(rst_req_in), .nmi_in(nmi_in),
        .lvl_in(lvl_in), .boundary(boundary), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .cur_sp(cur_sp), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_two(bus_two),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reset_req(reset_req), .entry_vld(entry_vld), .redir_pc(redir_pc),
        .new_sr(new_sr), .new_sp(new_sp), .st_word_addr(st_word_addr),
        .st_word_data(st_word_data), .st_half_addr(st_half_addr),
        .st_half_data(st_half_data), .ack_vld(ack_vld), .ack_lvl(ack_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] vec_val(input int i);
        return 16'h1000 + 16'(i) * 16'h0111;
    endfunction

    task automatic bus_write(input logic [6:0] a, input logic [15:0] d, input logic two);
        bus_sel = 1; bus_wr = 1; bus_two = two; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0; bus_two = 0;
    endtask

    task automatic bus_read_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
        bus_sel = 1; bus_wr = 0; bus_two = 1; bus_addr = a;
        #5 chk(req, {16'h0, bus_rdata}, {16'h0, exp});
        step();
        bus_sel = 0;
    endtask

    task automatic chk_nmi_entry(input string req);
        chk(req, {31'h0, entry_vld}, 32'h1);
        chk(req, {31'h0, ack_vld}, 32'h0);
        chk(req, redir_pc, 32'h4000_0008);
        chk(req, {16'h0, new_sr}, {16'h0, cur_sr & 16'hF7FF});
        chk(req, new_sp, cur_sp - 32'd8);
        chk(req, st_word_addr, cur_sp - 32'd4);
        chk(req, st_word_data, cur_pc);
        chk(req, st_half_addr, cur_sp - 32'd8);
        chk(req, {16'h0, st_half_data}, {16'h0, cur_sr});
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1; rst_req_in = 0; nmi_in = 0; boundary = 0; lvl_in = 3'd7;
        cur_pc = 32'h0000_1234; cur_sp = 32'h0000_8000; cur_sr = 16'h0F00;
        bus_sel = 0; bus_wr = 0; bus_two = 0; bus_addr = '0; bus_wdata = '0;
        @(negedge clk); step(); step();
        rst = 0;

        // R8: nothing pending after reset, even with enable and max mask
        cur_sr = 16'h0F00; boundary = 1;
        #5 chk("R8", {30'h0, reset_req, entry_vld}, 32'h0);
        step(); boundary = 0;
        for (int i = 0; i < 7; i++) bus_read_chk("R8", 7'(4 * i), 16'h0000);

        // R9: program and read back vectors
        for (int i = 0; i < 7; i++) bus_write(7'(4 * i), vec_val(i), 1'b1);
        for (int i = 0; i < 7; i++) bus_read_chk("R9", 7'(4 * i), vec_val(i));

        // R10: constant words and undecoded offsets
        bus_read_chk("R10", 7'h20, 16'h00C3);
        bus_read_chk("R10", 7'h40, 16'h0051);
        bus_read_chk("R10", 7'h1C, 16'h0000);
        bus_read_chk("R10", 7'h02, 16'h0000);
        bus_read_chk("R10", 7'h44, 16'h0000);

        // R11: wrong size and non-vector offsets leave state
        bus_write(7'h00, 16'hDEAD, 1'b0);
        bus_write(7'h18, 16'hBEEF, 1'b0);
        bus_write(7'h20, 16'hAAAA, 1'b1);
        bus_write(7'h1C, 16'h5555, 1'b1);
        bus_write(7'h01, 16'h7777, 1'b1);
        for (int i = 0; i < 7; i++) bus_read_chk("R11", 7'(4 * i), vec_val(i));
        bus_read_chk("R11", 7'h20, 16'h00C3);

        // R5 R6 R7: full sweep of level x mask x enable
        for (int lv = 0; lv < 8; lv++) begin
            lvl_in = 3'(lv);
            step();
            for (int m = 0; m < 8; m++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    logic take;
                    cur_sr = 16'hF0A5 | (16'(ie) << 11) | (16'(m) << 8);
                    cur_pc = 32'h0000_2000 + 32'(lv * 16 + m * 2 + ie);
                    take = (ie == 1) && (lv < m);
                    boundary = 1;
                    #5;
                    chk("R5", {31'h0, entry_vld}, {31'h0, take});
                    chk("R7", {31'h0, ack_vld}, {31'h0, take});
                    if (take) begin
                        chk("R7", {29'h0, ack_lvl}, 32'(lv));
                        chk("R6", redir_pc, 32'h4000_0000 + {16'h0, vec_val(lv)});
                        chk("R6", {16'h0, new_sr}, {16'h0, (cur_sr & 16'hF0FF & 16'hF7FF) | (16'(lv) << 8)});
                        chk("R4", new_sp, cur_sp - 32'd8);
                        chk("R4", st_word_addr, cur_sp - 32'd4);
                        chk("R4", st_word_data, cur_pc);
                        chk("R4", st_half_addr, cur_sp - 32'd8);
                        chk("R4", {16'h0, st_half_data}, {16'h0, cur_sr});
                    end
                    step();
                    boundary = 0;
                end
            end
        end

        // R1 R3 R4: NMI beats a grantable level, is not taken without boundary
        lvl_in = 3'd2; cur_sr = 16'h0F00; cur_sp = 32'h0000_9000;
        nmi_in = 1; step(); nmi_in = 0;
        #5 chk("R1", {30'h0, reset_req, entry_vld}, 32'h0);
        step();
        boundary = 1;
        #5 chk_nmi_entry("R3");
        step();
        #5;
        chk("R3", {31'h0, ack_vld}, 32'h1);
        chk("R3", redir_pc, 32'h4000_0000 + {16'h0, vec_val(2)});
        step(); boundary = 0;

        // R3: NMI taken with enable clear and mask 0
        cur_sr = 16'h0000; lvl_in = 3'd7;
        nmi_in = 1; step(); nmi_in = 0;
        boundary = 1;
        #5 chk_nmi_entry("R4");
        step();
        #5 chk("R3", {31'h0, entry_vld}, 32'h0);
        step(); boundary = 0;

        // R2 R1: reset first, then NMI, then level
        cur_sr = 16'h0F00; lvl_in = 3'd5;
        rst_req_in = 1; nmi_in = 1; step(); rst_req_in = 0; nmi_in = 0;
        boundary = 1;
        #5;
        chk("R2", {31'h0, reset_req}, 32'h1);
        chk("R2", {31'h0, entry_vld}, 32'h0);
        step();
        #5;
        chk("R2", {31'h0, reset_req}, 32'h0);
        chk_nmi_entry("R1");
        step();
        #5;
        chk("R1", {31'h0, ack_vld}, 32'h1);
        chk("R1", {29'h0, ack_lvl}, 32'd5);
        step(); boundary = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule